// File: doc/BRIEF.md
# Snapshot-Difference Phase Comparator

This block judges how closely two periodic signals of the same frequency are aligned in phase. Each system clock cycle it receives two tap snapshots, one from each of two mirrored delay lines, already registered in the system clock domain. The snapshots are compared bit by bit with XOR. The number of disagreeing taps is a raw measure of misalignment: two identical snapshots give zero, which means the inputs are in phase.

The raw count changes a great deal from one cycle to the next, so it is smoothed by a boxcar (finite-impulse-response moving-average) filter. The filter keeps a running sum and a circular buffer of the most recent samples. The window length is a power of two that can be selected at run time. The mean is the running sum shifted right by the base-two log of the window length. No edge or transition detection comes before the filter: the XOR count goes straight in.

A separate controller steps a phase shifter and reads the filtered value for each step. It pulses the clear input whenever the shift changes, so that every setting is measured from an empty window. It then looks for the smallest filtered value, because a smaller value means a smaller phase difference.

The filter is controlled by two states. In FILL the window is not yet complete. The transition FILL to RUN (window complete) happens when the last sample of the selected window is accumulated. In RUN each new sample replaces the oldest one. The transition RUN to FILL (restart) happens on a clear or on a change of the selected length. A clear or length change while in FILL is the transition FILL to FILL (restart), which zeroes the partial window.

Top module: `phase_snap_cmp`

## Requirements
- R1: While reset is held, and before the first clock edge after it is released, `valid_o` is 0 and `avg_o` is 0.
- R2: The per-cycle sample is the number of bit positions in which `snap_a_i` and `snap_b_i` differ, from 0 to 256. Identical snapshots give 0.
- R3: A snapshot pair captured at a clock edge enters the running sum at the next edge. `avg_o` always equals the sum of the samples currently in the window, shifted right by the selected length exponent (floor of sum / 2^L).
- R4: `valid_o` stays 0 after a restart until 2^L samples have entered the sum. It rises at the edge that accumulates the 2^L-th sample.
- R5: Once the window is full, each new sample displaces the oldest one, so `avg_o` tracks the mean of the latest 2^L samples.
- R6: `clear_i` is synchronous. At a clock edge where it is 1, the sum and window are emptied, and the pair captured at that edge is discarded, as is the pair captured one edge earlier. After that edge `avg_o` is 0 and `valid_o` is 0. Accumulation resumes with the pair captured at the first edge where `clear_i` is 0.
- R7: At a clock edge where the effective length exponent differs from the one in use, the block restarts exactly as for a clear and adopts the new length.
- R8: The length select `len_i` is an exponent L. Values below 4 act as 4, and values above MAX_LOG2 (default 11) act as MAX_LOG2. The reset-time exponent is 4.
- R9: A full-scale difference (all 256 taps differ on every cycle) yields `avg_o` = 256 once the window is full, with no wraparound of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous window clear |
| len_i | input | 4 | Window length exponent L (window of 2^L samples) |
| snap_a_i | input | 256 | Registered tap snapshot of the first delay line |
| snap_b_i | input | 256 | Registered tap snapshot of the second delay line |
| avg_o | output | 9 | Filtered misalignment value |
| valid_o | output | 1 | Window is full and `avg_o` is a complete mean |

## Verification
The hardest situation to reach from the ports is the interaction of the sliding window with a restart. In that case the popcount stage holds a sample in flight while the filter is being emptied, and that sample must not appear in the new window. The stimulus drives a clear and then a length change in the middle of RUN, with random snapshot pairs on every cycle. A reference window model predicts which samples survive. The largest window is then filled with full-scale differences, which pushes the running sum to its upper bound. That case also uses an out-of-range length request, so clamping is checked as well.

// File: rtl/phase_snap_pkg.sv
package phase_snap_pkg;

    typedef enum logic [0:0] {
        S_FILL = 1'b0,
        S_RUN  = 1'b1
    } win_state_e;

endpackage

// File: rtl/snap_popcount.sv
module snap_popcount #(
    parameter int TAPS  = 256,
    parameter int GROUP = 16,
    localparam int CNT_W = $clog2(TAPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [TAPS-1:0]  snap_a_i,
    input  logic [TAPS-1:0]  snap_b_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cnt_vld_o
);

    localparam int NGRP  = TAPS / GROUP;
    localparam int GRP_W = $clog2(GROUP + 1);

    logic [TAPS-1:0]  diff;
    logic [GRP_W-1:0] grp_cnt [NGRP];
    logic [CNT_W-1:0] total;

    assign diff = snap_a_i ^ snap_b_i;

    // one small adder per group of taps, then a sum of the groups
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GRP_W-1:0] part;
        always_comb begin
            part = '0;
            for (int i = 0; i < GROUP; i++) begin
                part = part + GRP_W'(diff[g*GROUP + i]);
            end
        end
        assign grp_cnt[g] = part;
    end

    always_comb begin
        total = '0;
        for (int g = 0; g < NGRP; g++) begin
            total = total + CNT_W'(grp_cnt[g]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o     <= '0;
            cnt_vld_o <= 1'b0;
        end else if (flush_i) begin
            cnt_o     <= '0;
            cnt_vld_o <= 1'b0;
        end else begin
            cnt_o     <= total;
            cnt_vld_o <= 1'b1;
        end
    end

    // R2: the count never exceeds the number of taps
    p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_vld_o |-> (cnt_o <= CNT_W'(TAPS)));

    // R2: identical snapshots give a zero count
    p_identical_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_a_i == snap_b_i) |=> (cnt_o == '0));

endmodule

// File: rtl/ring_buf.sv
module ring_buf #(
    parameter int AW = 11,
    parameter int W  = 9
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // read-before-write at the same address: the oldest sample leaves as the new one lands
    assign rdata_o = mem[addr_i];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

endmodule

// File: rtl/boxcar_filter.sv
module boxcar_filter
    import phase_snap_pkg::*;
#(
    parameter int TAPS     = 256,
    parameter int MIN_LOG2 = 4,
    parameter int MAX_LOG2 = 11,
    localparam int CNT_W   = $clog2(TAPS + 1),
    localparam int LEN_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [CNT_W-1:0] smp_i,
    input  logic             smp_vld_i,
    output logic             flush_o,
    output logic [CNT_W-1:0] avg_o,
    output logic             valid_o
);

    localparam int SUM_W = CNT_W + MAX_LOG2;
    localparam int IDX_W = MAX_LOG2 + 1;

    win_state_e       state_q, state_d;
    logic [LEN_W-1:0] len_q, len_eff;
    logic [IDX_W-1:0] cnt_q, win_last;
    logic [MAX_LOG2-1:0] wr_q;
    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] old_smp;
    logic             restart;
    logic             last_in;

    // clamp the requested exponent into the supported range
    always_comb begin
        if (len_i < LEN_W'(MIN_LOG2)) begin
            len_eff = LEN_W'(MIN_LOG2);
        end else if (len_i > LEN_W'(MAX_LOG2)) begin
            len_eff = LEN_W'(MAX_LOG2);
        end else begin
            len_eff = len_i;
        end
    end

    assign restart  = clr_i || (len_eff != len_q);
    assign flush_o  = restart;
    assign win_last = (IDX_W'(1) << len_q) - IDX_W'(1);
    assign last_in  = smp_vld_i && (cnt_q == win_last);

    ring_buf #(
        .AW (MAX_LOG2),
        .W  (CNT_W)
    ) i_ring (
        .clk     (clk),
        .we_i    (smp_vld_i && !restart),
        .addr_i  (wr_q),
        .wdata_i (smp_i),
        .rdata_o (old_smp)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FILL: begin
                if (restart) begin
                    state_d = S_FILL;
                end else if (last_in) begin
                    state_d = S_RUN;
                end
            end
            S_RUN: begin
                if (restart) begin
                    state_d = S_FILL;
                end
            end
            default: state_d = S_FILL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath: running sum, fill counter, write pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
            wr_q  <= '0;
            len_q <= LEN_W'(MIN_LOG2);
        end else if (restart) begin
            sum_q <= '0;
            cnt_q <= '0;
            wr_q  <= '0;
            len_q <= len_eff;
        end else if (smp_vld_i) begin
            if (state_q == S_RUN) begin
                sum_q <= sum_q + SUM_W'(smp_i) - SUM_W'(old_smp);
            end else begin
                sum_q <= sum_q + SUM_W'(smp_i);
                if (!last_in) begin
                    cnt_q <= cnt_q + IDX_W'(1);
                end
            end
            wr_q <= (wr_q + MAX_LOG2'(1)) & win_last[MAX_LOG2-1:0];
        end
    end

    // outputs
    always_comb begin
        avg_o   = CNT_W'(sum_q >> len_q);
        valid_o = (state_q == S_RUN);
    end

    // R3: the running sum stays within the full-scale bound of the window
    p_sum_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, sum_q} <= ((SUM_W+1)'(TAPS) << len_q)));

    // R4: a full window means the fill counter reached the last index
    p_run_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cnt_q == win_last));

    // R6: a clear empties the window at the next edge
    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!valid_o && sum_q == '0));

    // R7: a length change restarts the fill with the new length
    p_len_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (len_eff != len_q) |=> (!valid_o && len_q == $past(len_eff)));

    // R8: the exponent in use is always inside the supported range
    p_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q >= LEN_W'(MIN_LOG2) && len_q <= LEN_W'(MAX_LOG2)));

endmodule

// File: rtl/phase_snap_cmp.sv
module phase_snap_cmp #(
    parameter int TAPS     = 256,
    parameter int GROUP    = 16,
    parameter int MIN_LOG2 = 4,
    parameter int MAX_LOG2 = 11,
    localparam int CNT_W   = $clog2(TAPS + 1),
    localparam int LEN_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [TAPS-1:0]  snap_a_i,
    input  logic [TAPS-1:0]  snap_b_i,
    output logic [CNT_W-1:0] avg_o,
    output logic             valid_o
);

    logic [CNT_W-1:0] pop;
    logic             pop_vld;
    logic             flush;

    snap_popcount #(
        .TAPS  (TAPS),
        .GROUP (GROUP)
    ) i_pop (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .snap_a_i  (snap_a_i),
        .snap_b_i  (snap_b_i),
        .cnt_o     (pop),
        .cnt_vld_o (pop_vld)
    );

    boxcar_filter #(
        .TAPS     (TAPS),
        .MIN_LOG2 (MIN_LOG2),
        .MAX_LOG2 (MAX_LOG2)
    ) i_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clear_i),
        .len_i     (len_i),
        .smp_i     (pop),
        .smp_vld_i (pop_vld),
        .flush_o   (flush),
        .avg_o     (avg_o),
        .valid_o   (valid_o)
    );

    // R9: the filtered value never exceeds full scale
    p_avg_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_o <= CNT_W'(TAPS)));

    // R6: a clear leaves the output at zero
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (avg_o == '0));

endmodule

// File: tb/test_phase_snap_cmp.sv
module test_phase_snap_cmp;

    localparam int TAPS     = 256;
    localparam int MIN_LOG2 = 4;
    localparam int MAX_LOG2 = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clear_i = 1'b0;
    logic [3:0]       len_i = 4'd4;
    logic [TAPS-1:0]  snap_a_i = '0;
    logic [TAPS-1:0]  snap_b_i = '0;
    logic [8:0]       avg_o;
    logic             valid_o;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        int    avg;
        bit    vld;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // reference window model
    int win[$];
    int pend;
    bit pend_v = 0;
    int m_len  = MIN_LOG2;

    always #10 clk = ~clk;

    phase_snap_cmp i_phase_snap_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .len_i    (len_i),
        .snap_a_i (snap_a_i),
        .snap_b_i (snap_b_i),
        .avg_o    (avg_o),
        .valid_o  (valid_o)
    );

    function automatic logic [TAPS-1:0] rnd_vec();
        logic [TAPS-1:0] v;
        for (int i = 0; i < TAPS / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus, advance the model, queue the expectation
    task automatic step(input logic [TAPS-1:0] a, input logic [TAPS-1:0] b,
                        input bit clr, input int len, input string tag);
        int   le;
        int   sum;
        exp_t e;
        snap_a_i = a;
        snap_b_i = b;
        clear_i  = clr;
        len_i    = 4'(len);
        le = (len < MIN_LOG2) ? MIN_LOG2 : ((len > MAX_LOG2) ? MAX_LOG2 : len);
        @(posedge clk);
        if (clr || le != m_len) begin
            win.delete();
            pend_v = 0;
            m_len  = le;
        end else begin
            if (pend_v) begin
                win.push_back(pend);
                if (win.size() > (1 << m_len)) void'(win.pop_front());
            end
            pend   = $countones(a ^ b);
            pend_v = 1;
        end
        sum = 0;
        foreach (win[i]) sum += win[i];
        e.avg = sum >> m_len;
        e.vld = (win.size() == (1 << m_len));
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, int'(avg_o), e.avg, "avg_o");
            check(e.tag, int'(valid_o), int'(e.vld), "valid_o");
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [TAPS-1:0] a;
        int rise_at;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1", int'(avg_o), 0, "avg_o in reset");
        check("R1", int'(valid_o), 0, "valid_o in reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: before any edge after release nothing changed... one edge passed; window still empty
        check("R1", int'(valid_o), 0, "valid_o after release");
        step('0, '0, 1'b1, 4, "R1");

        // R2: identical snapshots give zero
        for (int k = 0; k < 24; k++) begin
            a = rnd_vec();
            step(a, a, 1'b0, 4, "R2");
        end

        // R3 / R5: random differences, sliding window at length 16
        for (int k = 0; k < 60; k++) begin
            step(rnd_vec(), rnd_vec(), 1'b0, 4, "R5");
        end

        // R4: valid rises exactly when the 16th sample enters
        step('0, '0, 1'b1, 4, "R6");
        rise_at = -1;
        for (int k = 0; k < 20; k++) begin
            step(rnd_vec(), rnd_vec(), 1'b0, 4, "R4");
            if (valid_o && rise_at < 0) rise_at = k;
        end
        // pairs k=0..15 captured, the 16th enters at step index 16
        check("R4", rise_at, 16, "steps until valid");

        // R6: clear in the middle of a full window
        for (int k = 0; k < 6; k++) step(rnd_vec(), rnd_vec(), 1'b0, 4, "R6");
        step(rnd_vec(), rnd_vec(), 1'b1, 4, "R6");
        step(rnd_vec(), rnd_vec(), 1'b1, 4, "R6");
        for (int k = 0; k < 24; k++) step(rnd_vec(), rnd_vec(), 1'b0, 4, "R6");

        // R7: length change mid-run
        for (int k = 0; k < 40; k++) step(rnd_vec(), rnd_vec(), 1'b0, 5, "R7");
        for (int k = 0; k < 20; k++) step(rnd_vec(), rnd_vec(), 1'b0, 4, "R7");

        // R8: exponent below range acts as the minimum (no restart expected)
        for (int k = 0; k < 20; k++) step(rnd_vec(), rnd_vec(), 1'b0, 2, "R8");

        // R8 / R9: above-range request clamps to the largest window, full-scale data
        for (int k = 0; k < (1 << MAX_LOG2) + 40; k++) begin
            a = rnd_vec();
            step(a, ~a, 1'b0, 15, "R9");
        end
        check("R9", int'(avg_o), 256, "full-scale mean");
        check("R8", int'(valid_o), 1, "clamped window full");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule